// File: doc/BRIEF.md
# Display command list interpreter

This block runs a linked program of 64-bit commands on behalf of a graphics controller. It fetches each command from memory through a request/valid read port and executes it. The commands load engine registers singly or in inline bursts, wait on a masked pattern of hardware status, jump absolutely or relatively, call and return through a single return-address register, branch on a host-written condition register, and finish with an optional interrupt.

A host control word starts, stops and resumes the program. Reading it back returns the address of the command now executing, an idle flag and the start flag. An undefined opcode halts the program and latches an error flag that the host can clear.

Each command word places its opcode in bits 31:28 and a 28-bit address or offset in bits 27:0. Bits 63:32 carry the data or the argument.

Top module: `cmdlist_engine`

## Requirements
- R1: After reset the control readback is 0x4000_0000 (address 0, idle bit 30 set, start bit 31 clear), and no memory request, register write, interrupt or error flag is active.
- R2: A control write while idle loads the address field from bits 27:3 (bits 2:0 forced to zero) and sets the start bit to bit 31; if bit 31 is 1, fetching begins at that address. While busy, a control write changes only the start bit and leaves the address unchanged. The address field always shows the command being executed.
- R3: Every fetch address is a multiple of 8, and a request stays asserted with a stable address until mem_valid is seen.
- R4: Opcode 0x1 writes bits 63:32 to the register address taken from bits 20:0 with bits 1:0 forced to zero.
- R5: Opcode 0x3 takes a dword count from bits 63:32 and writes that many inline dwords to consecutive register addresses stepping by 4. Inline data starts 8 bytes after the command, with the low dword of each 64-bit word first. The next command follows the last inline word, so an odd count skips the padding dword, and a count of zero writes nothing.
- R6: Opcode 0x6 stalls while (hw_status AND bits 20:0) differs from (bits 52:32 AND bits 20:0) and continues with the next command once they match. Unmasked status bits have no effect.
- R7: Opcode 0x9 jumps to bits 27:3 of the command. When bit 32 is set, that field is instead a signed offset added, modulo 2^28, to the address of the goto itself.
- R8: Opcode 0xB saves the address of the following command and then jumps like a goto. Opcode 0xA jumps to the saved address.
- R9: Opcode 0xC adds the signed offset in bits 27:3 to the address of the following command when (bits 63:32 AND condition register) is nonzero; otherwise execution falls through.
- R10: Opcode 0x8 clears the start bit and leaves the block idle, with the address field on the finish command. If bit 0 of the command is set, it sets a sticky pending flag. The irq output is the pending flag gated by irq_en, and irq_clr clears the flag.
- R11: Clearing the start bit halts the block after the command in flight completes, or at once while a status test is waiting. Writing the start bit back with the shown address resumes from that command.
- R12: Any opcode other than 0x1, 0x3, 0x6, 0x8, 0x9, 0xA, 0xB and 0xC stops the block the way a finish does, raises no interrupt and sets a sticky err_flag, which err_clr clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Control word write strobe |
| host_wdata | input | 32 | Control word: start in bit 31, address in bits 27:3 |
| ctrl_rd | output | 32 | Readback: start, idle, current command address |
| cond_we | input | 1 | Condition register write strobe |
| cond_wdata | input | 32 | Condition register value |
| hw_status | input | STAT_W (21) | Hardware status bits for the status test |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 28 | Byte address of the 64-bit word to read |
| mem_valid | input | 1 | Read data valid; ends the request |
| mem_rdata | input | 64 | Read data |
| reg_we | output | 1 | Engine register write strobe |
| reg_addr | output | REG_AW (21) | Engine register byte address |
| reg_wdata | output | 32 | Engine register write data |
| irq_en | input | 1 | Interrupt mask (1 passes the interrupt) |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Interrupt request |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky undefined-opcode flag |

## Verification
The assertions assume that mem_valid pulses for one cycle only while a request is outstanding. They also assume that a host control write never lands in the same cycle as the finish it would contend with. The bench memory model answers exactly one cycle after it sees a request and never raises valid unprompted. Programs and inline data stay inside the 2 KB model, and control writes arrive only when the block is idle or stalled in a status test, or early enough in a run to stop it at a command boundary.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

    localparam int CMD_W  = 64;
    localparam int AW     = 28;
    localparam int WORD_W = 32;

    localparam logic [3:0] OP_LDREG = 4'h1;
    localparam logic [3:0] OP_LDIMM = 4'h3;
    localparam logic [3:0] OP_STAT  = 4'h6;
    localparam logic [3:0] OP_FIN   = 4'h8;
    localparam logic [3:0] OP_GOTO  = 4'h9;
    localparam logic [3:0] OP_RET   = 4'hA;
    localparam logic [3:0] OP_GOSUB = 4'hB;
    localparam logic [3:0] OP_CJMP  = 4'hC;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_EXEC   = 3'd2,
        ST_DFETCH = 3'd3,
        ST_DLO    = 3'd4,
        ST_DHI    = 3'd5
    } cl_state_e;

    typedef struct packed {
        logic ldreg;
        logic ldimm;
        logic stat;
        logic fin;
        logic gto;
        logic gsub;
        logic ret;
        logic cjmp;
        logic bad;
    } cl_op_t;

endpackage

// File: rtl/cmdlist_sticky.sv
module cmdlist_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/cmdlist_decode.sv
module cmdlist_decode
    import cmdlist_pkg::*;
#(
    parameter int STAT_W = 21
) (
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [WORD_W-1:0] cond_i,
    input  logic [STAT_W-1:0] hw_status_i,
    output cl_op_t            op_o,
    output logic              stat_ok_o,
    output logic [AW-1:0]     seq_pc_o,
    output logic [AW-1:0]     jmp_pc_o,
    output logic [AW-1:0]     cjmp_pc_o,
    output logic [WORD_W-1:0] arg_o
);
    logic [3:0]        opc;
    logic [AW-1:0]     off;
    logic [STAT_W-1:0] mask, want;
    logic              unused_bits;

    assign opc   = cmd_i[31:28];
    assign off   = {cmd_i[AW-1:3], 3'b000};
    assign arg_o = cmd_i[63:32];
    assign mask  = cmd_i[STAT_W-1:0];
    assign want  = cmd_i[32+STAT_W-1:32];

    assign unused_bits = ^{cmd_i[2:0]};

    always_comb begin
        op_o = '0;
        unique case (opc)
            OP_LDREG: op_o.ldreg = 1'b1;
            OP_LDIMM: op_o.ldimm = 1'b1;
            OP_STAT:  op_o.stat  = 1'b1;
            OP_FIN:   op_o.fin   = 1'b1;
            OP_GOTO:  op_o.gto   = 1'b1;
            OP_RET:   op_o.ret   = 1'b1;
            OP_GOSUB: op_o.gsub  = 1'b1;
            OP_CJMP:  op_o.cjmp  = 1'b1;
            default:  op_o.bad   = 1'b1;
        endcase
    end

    assign seq_pc_o  = pc_i + AW'(8);
    assign jmp_pc_o  = cmd_i[32] ? (pc_i + off) : off;
    assign cjmp_pc_o = (|(arg_o & cond_i)) ? (seq_pc_o + off) : seq_pc_o;
    assign stat_ok_o = ((hw_status_i & mask) == (want & mask));
endmodule

// File: rtl/cmdlist_engine.sv
module cmdlist_engine
    import cmdlist_pkg::*;
#(
    parameter int STAT_W = 21,
    parameter int REG_AW = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       ctrl_rd,
    input  logic              cond_we,
    input  logic [31:0]       cond_wdata,
    input  logic [STAT_W-1:0] hw_status,
    output logic              mem_req,
    output logic [27:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [63:0]       mem_rdata,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq,
    input  logic              err_clr,
    output logic              err_flag
);
    localparam int NFLAG = 2;

    typedef struct packed {
        cl_state_e           state;
        logic                start;
        logic [AW-1:0]       pc;
        logic [AW-1:0]       ret;
        logic [AW-1:0]       daddr;
        logic [WORD_W-1:0]   rem;
        logic [REG_AW-1:0]   raddr;
        logic [WORD_W-1:0]   cond;
        logic [CMD_W-1:0]    cmd;
        logic [CMD_W-1:0]    dword;
    } regs_t;

    regs_t q, n;

    cl_op_t            op;
    logic              stat_ok;
    logic [AW-1:0]     seq_pc, jmp_pc, cjmp_pc;
    logic [WORD_W-1:0] arg;
    logic              adv, set_irq, set_err, irq_pend;
    logic              unused_host;
    logic [NFLAG-1:0]  stk_set, stk_clr, stk_q;

    assign unused_host = ^{host_wdata[30:28], host_wdata[2:0]};

    cmdlist_decode #(.STAT_W(STAT_W)) u_dec (
        .cmd_i       (q.cmd),
        .pc_i        (q.pc),
        .cond_i      (q.cond),
        .hw_status_i (hw_status),
        .op_o        (op),
        .stat_ok_o   (stat_ok),
        .seq_pc_o    (seq_pc),
        .jmp_pc_o    (jmp_pc),
        .cjmp_pc_o   (cjmp_pc),
        .arg_o       (arg)
    );

    always_comb begin
        n         = q;
        adv       = 1'b0;
        set_irq   = 1'b0;
        set_err   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = q.raddr;
        reg_wdata = '0;
        mem_req   = 1'b0;
        mem_addr  = q.pc;

        if (cond_we) n.cond = cond_wdata;

        if (host_we) begin
            n.start = host_wdata[31];
            if (q.state == ST_IDLE) begin
                n.pc = {host_wdata[AW-1:3], 3'b000};
                if (host_wdata[31]) n.state = ST_FETCH;
            end
        end

        unique case (q.state)
            ST_IDLE: ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.pc;
                if (mem_valid) begin
                    n.cmd   = mem_rdata;
                    n.state = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (op.ldreg) begin
                    reg_we    = 1'b1;
                    reg_addr  = {q.cmd[REG_AW-1:2], 2'b00};
                    reg_wdata = arg;
                    n.pc      = seq_pc;
                    adv       = 1'b1;
                end else if (op.ldimm) begin
                    if (arg == '0) begin
                        n.pc = seq_pc;
                        adv  = 1'b1;
                    end else begin
                        n.rem   = arg;
                        n.raddr = {q.cmd[REG_AW-1:2], 2'b00};
                        n.daddr = seq_pc;
                        n.state = ST_DFETCH;
                    end
                end else if (op.stat) begin
                    if (stat_ok) begin
                        n.pc = seq_pc;
                        adv  = 1'b1;
                    end else if (!n.start) begin
                        n.state = ST_IDLE;
                    end
                end else if (op.gto) begin
                    n.pc = jmp_pc;
                    adv  = 1'b1;
                end else if (op.gsub) begin
                    n.ret = seq_pc;
                    n.pc  = jmp_pc;
                    adv   = 1'b1;
                end else if (op.ret) begin
                    n.pc = q.ret;
                    adv  = 1'b1;
                end else if (op.cjmp) begin
                    n.pc = cjmp_pc;
                    adv  = 1'b1;
                end else if (op.fin) begin
                    n.start = 1'b0;
                    n.state = ST_IDLE;
                    set_irq = q.cmd[0];
                end else begin
                    n.start = 1'b0;
                    n.state = ST_IDLE;
                    set_err = 1'b1;
                end
            end
            ST_DFETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.daddr;
                if (mem_valid) begin
                    n.dword = mem_rdata;
                    n.state = ST_DLO;
                end
            end
            ST_DLO: begin
                reg_we    = 1'b1;
                reg_wdata = q.dword[31:0];
                n.raddr   = q.raddr + REG_AW'(4);
                n.rem     = q.rem - 32'd1;
                if (q.rem == 32'd1) begin
                    n.pc = q.daddr + AW'(8);
                    adv  = 1'b1;
                end else begin
                    n.state = ST_DHI;
                end
            end
            ST_DHI: begin
                reg_we    = 1'b1;
                reg_wdata = q.dword[63:32];
                n.raddr   = q.raddr + REG_AW'(4);
                n.rem     = q.rem - 32'd1;
                n.daddr   = q.daddr + AW'(8);
                if (q.rem == 32'd1) begin
                    n.pc = q.daddr + AW'(8);
                    adv  = 1'b1;
                end else begin
                    n.state = ST_DFETCH;
                end
            end
            default: n.state = ST_IDLE;
        endcase

        if (adv) n.state = n.start ? ST_FETCH : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign stk_set = {set_err, set_irq};
    assign stk_clr = {err_clr, irq_clr};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        cmdlist_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (stk_set[g]),
            .clr_i (stk_clr[g]),
            .q_o   (stk_q[g])
        );
    end

    assign irq_pend = stk_q[0];
    assign err_flag = stk_q[1];
    assign irq      = irq_pend & irq_en;
    assign ctrl_rd  = {q.start, (q.state == ST_IDLE), 2'b00, q.pc};

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R3
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R4
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr[1:0] == 2'b00));

    // R6
    stat_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_EXEC && op.stat && !stat_ok && q.start && !host_we)
        |=> (q.state == ST_EXEC && $stable(q.pc)));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(q.state == ST_EXEC && op.fin));

    // R12
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(q.state == ST_EXEC && op.bad));

    // R11
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rd[30]) |-> !ctrl_rd[31]);
endmodule

// File: tb/cmdlist_engine_bench.sv
`timescale 1ns/1ps
module cmdlist_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] ctrl_rd;
    logic        cond_we = 1'b0;
    logic [31:0] cond_wdata = '0;
    logic [20:0] hw_status = '0;
    logic        mem_req;
    logic [27:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        reg_we;
    logic [20:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        irq_en = 1'b1;
    logic        irq_clr = 1'b0;
    logic        irq;
    logic        err_clr = 1'b0;
    logic        err_flag;

    int total = 0;
    int bad = 0;
    int misalign = 0;
    int lg_n = 0;
    logic [20:0] lg_a [0:255];
    logic [31:0] lg_d [0:255];
    logic [63:0] mem [0:255];

    always #2 clk = ~clk;

    cmdlist_engine u_cmdlist_engine (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .ctrl_rd(ctrl_rd), .cond_we(cond_we), .cond_wdata(cond_wdata),
        .hw_status(hw_status), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_en(irq_en),
        .irq_clr(irq_clr), .irq(irq), .err_clr(err_clr), .err_flag(err_flag)
    );

    always @(posedge clk) begin
        mem_valid <= mem_req && !mem_valid;
        mem_rdata <= mem[mem_addr[10:3]];
    end

    always @(negedge clk) begin
        if (reg_we) begin
            lg_a[lg_n[7:0]] <= reg_addr;
            lg_d[lg_n[7:0]] <= reg_wdata;
            lg_n <= lg_n + 1;
        end
        if (mem_req && mem_addr[2:0] != 3'b000) misalign <= misalign + 1;
    end

    function automatic logic [63:0] mk(input logic [3:0] op, input logic [27:0] lo,
                                       input logic [31:0] hi);
        return {hi, op, lo};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [63:0] v);
        mem[addr[10:3]] = v;
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 256; i++) mem[i] = mk(4'h8, 28'h0, 32'h0);
    endtask

    task automatic host_write(input logic [31:0] v);
        @(negedge clk); host_we = 1'b1; host_wdata = v;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k;
        k = 0;
        while (!ctrl_rd[30] && k < 3000) begin
            @(negedge clk); k++;
        end
        @(negedge clk);
        chk(req, 64'(ctrl_rd[30]), 64'd1);
    endtask

    task automatic run(input int addr, input string req);
        host_write(32'h8000_0000 | 32'(addr));
        @(negedge clk);
        wait_idle(req);
    endtask

    task automatic set_cond(input logic [31:0] v);
        @(negedge clk); cond_we = 1'b1; cond_wdata = v;
        @(negedge clk); cond_we = 1'b0;
    endtask

    task automatic exp_wr(input string req, input int idx, input logic [20:0] a,
                          input logic [31:0] d);
        chk(req, 64'(lg_a[idx[7:0]]), 64'(a));
        chk(req, 64'(lg_d[idx[7:0]]), 64'(d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, nx, b0, cnt;
        logic [31:0] cv;
        logic take;
        logic [3:0] badops [0:7];
        badops[0] = 4'h0; badops[1] = 4'h2; badops[2] = 4'h4; badops[3] = 4'h5;
        badops[4] = 4'h7; badops[5] = 4'hD; badops[6] = 4'hE; badops[7] = 4'hF;
        clr_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctrl", 64'(ctrl_rd), 64'h4000_0000);
        chk("R1 req", 64'(mem_req), 64'd0);
        chk("R1 we", 64'(reg_we), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 err", 64'(err_flag), 64'd0);

        // R4, R2, R10: two register loads and a finish with interrupt
        clr_mem();
        put(32'h40, mk(4'h1, 28'h123, 32'hA5A5_0001));
        put(32'h48, mk(4'h1, 28'h1F_FFFF, 32'h0000_0002));
        put(32'h50, mk(4'h8, 28'h1, 32'h0));
        b0 = lg_n;
        run(32'h43, "R2 start");
        chk("R4 count", 64'(lg_n - b0), 64'd2);
        exp_wr("R4 first", b0, 21'h120, 32'hA5A5_0001);
        exp_wr("R4 second", b0 + 1, 21'h1F_FFFC, 32'h2);
        chk("R10 ctrl after finish", 64'(ctrl_rd), 64'h4000_0050);
        chk("R10 irq raised", 64'(irq), 64'd1);
        pulse_irq_clr();
        chk("R10 irq cleared", 64'(irq), 64'd0);
        irq_en = 1'b0;
        run(32'h40, "R10 masked run");
        chk("R10 irq masked", 64'(irq), 64'd0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R10 pending kept", 64'(irq), 64'd1);
        pulse_irq_clr();

        // R5 inline burst sweep, counts 0..7
        for (int n = 0; n < 8; n++) begin
            clr_mem();
            base = 32'h100;
            put(base, mk(4'h3, 28'h400, 32'(n)));
            for (int j = 0; j < (n + 1) / 2; j++) begin
                put(base + 8 + 8 * j,
                    {((2 * j + 1 < n) ? 32'(32'hD000 + 2 * j + 1) : 32'hBAD),
                     32'(32'hD000 + 2 * j)});
            end
            nx = base + 8 + 8 * ((n + 1) / 2);
            put(nx, mk(4'h1, 28'h7FC, 32'(n)));
            put(nx + 8, mk(4'h8, 28'h0, 32'h0));
            b0 = lg_n;
            run(base, "R5 run");
            chk("R5 write count", 64'(lg_n - b0), 64'(n + 1));
            for (int i = 0; i < n; i++)
                exp_wr("R5 data", b0 + i, 21'(32'h400 + 4 * i), 32'(32'hD000 + i));
            exp_wr("R5 next command", b0 + n, 21'h7FC, 32'(n));
            chk("R5 final address", 64'(ctrl_rd), 64'(32'h4000_0000 | (nx + 8)));
            chk("R10 no irq on plain finish", 64'(irq), 64'd0);
        end

        // R7 absolute and negative relative goto
        clr_mem();
        put(32'h200, mk(4'h9, 28'h300, 32'h0));
        put(32'h208, mk(4'h1, 28'h10, 32'hDEAD));
        put(32'h300, mk(4'h9, 28'hFFF_FF80, 32'h1));
        put(32'h280, mk(4'h1, 28'h10, 32'h77));
        b0 = lg_n;
        run(32'h200, "R7 run");
        chk("R7 count", 64'(lg_n - b0), 64'd1);
        exp_wr("R7 target", b0, 21'h10, 32'h77);
        chk("R7 final address", 64'(ctrl_rd[27:0]), 64'h288);

        // R8 gosub and return, absolute and relative
        for (int rel = 0; rel < 2; rel++) begin
            clr_mem();
            put(32'h0, mk(4'hB, 28'h380, 32'(rel)));
            put(32'h8, mk(4'h1, 28'h20, 32'h2));
            put(32'h380, mk(4'h1, 28'h24, 32'h1));
            put(32'h388, mk(4'hA, 28'h0, 32'h0));
            b0 = lg_n;
            run(32'h0, "R8 run");
            chk("R8 count", 64'(lg_n - b0), 64'd2);
            exp_wr("R8 in subroutine", b0, 21'h24, 32'h1);
            exp_wr("R8 after return", b0 + 1, 21'h20, 32'h2);
            chk("R8 final address", 64'(ctrl_rd[27:0]), 64'h10);
        end

        // R9 conditional jump over condition patterns
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: cv = 32'h0;
                1: cv = 32'h10;
                2: cv = 32'h0F;
                3: cv = 32'h8000_0080;
                default: cv = 32'hFFFF_FF0F;
            endcase
            take = |(cv & 32'h0000_00F0);
            set_cond(cv);
            clr_mem();
            put(32'h400, mk(4'hC, 28'h10, 32'h0000_00F0));
            put(32'h408, mk(4'h1, 28'h30, 32'hF));
            put(32'h418, mk(4'h1, 28'h30, 32'h7));
            b0 = lg_n;
            run(32'h400, "R9 run");
            chk("R9 count", 64'(lg_n - b0), 64'd1);
            exp_wr("R9 path", b0, 21'h30, take ? 32'h7 : 32'hF);
            chk("R9 final address", 64'(ctrl_rd[27:0]), take ? 64'h420 : 64'h410);
        end

        // R6, R11, R2: status wait, stop, resume, busy write
        clr_mem();
        hw_status = 21'h1_0000;
        put(32'h500, mk(4'h6, 28'h1_0801, 32'h0_0800));
        put(32'h508, mk(4'h1, 28'h40, 32'h55));
        b0 = lg_n;
        host_write(32'h8000_0500);
        repeat (20) @(negedge clk);
        chk("R6 stalled no write", 64'(lg_n - b0), 64'd0);
        chk("R6 stalled busy", 64'(ctrl_rd), 64'h8000_0500);
        host_write(32'h0);
        repeat (3) @(negedge clk);
        chk("R11 halted in wait", 64'(ctrl_rd), 64'h4000_0500);
        host_write(32'h8000_0500);
        repeat (10) @(negedge clk);
        host_write(32'h8000_0700);
        repeat (3) @(negedge clk);
        chk("R2 busy write keeps address", 64'(ctrl_rd), 64'h8000_0500);
        hw_status = 21'h0_0802;
        wait_idle("R6 released");
        chk("R6 one write", 64'(lg_n - b0), 64'd1);
        exp_wr("R6 after match", b0, 21'h40, 32'h55);
        chk("R6 final address", 64'(ctrl_rd[27:0]), 64'h510);

        // R11 stop at a command boundary, then resume
        clr_mem();
        for (int i = 0; i < 4; i++) put(32'h600 + 8 * i, mk(4'h1, 28'(32'h60 + 4 * i), 32'(i + 1)));
        b0 = lg_n;
        host_write(32'h8000_0600);
        host_write(32'h0);
        repeat (10) @(negedge clk);
        cnt = lg_n - b0;
        chk("R11 stopped idle", 64'(ctrl_rd[31:30]), 64'h1);
        chk("R11 stopped early", 64'(cnt < 4), 64'd1);
        chk("R11 boundary address", 64'(ctrl_rd[27:0]), 64'(32'h600 + 8 * cnt));
        run(32'(ctrl_rd[27:0]), "R11 resume");
        chk("R11 total writes", 64'(lg_n - b0), 64'd4);
        for (int i = 0; i < 4; i++)
            exp_wr("R11 order", b0 + i, 21'(32'h60 + 4 * i), 32'(i + 1));

        // R12 undefined opcode sweep
        for (int k = 0; k < 8; k++) begin
            clr_mem();
            put(32'h700, mk(4'h1, 28'h50, 32'(k)));
            put(32'h708, mk(badops[k], 28'h1, 32'h0));
            put(32'h710, mk(4'h1, 28'h54, 32'hBEEF));
            b0 = lg_n;
            run(32'h700, "R12 run");
            chk("R12 err set", 64'(err_flag), 64'd1);
            chk("R12 no irq", 64'(irq), 64'd0);
            chk("R12 stopped at bad", 64'(ctrl_rd), 64'h4000_0708);
            chk("R12 one write", 64'(lg_n - b0), 64'd1);
            @(negedge clk); err_clr = 1'b1;
            @(negedge clk); err_clr = 1'b0;
            chk("R12 err cleared", 64'(err_flag), 64'd0);
        end

        chk("R3 fetch alignment", 64'(misalign), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule